// File: doc/BRIEF.md
# Bridge Brake and Overcurrent Fault Controller

This block is the digital core that sits between a motor controller's PWM outputs and the six gate drivers of a three-phase half-bridge. It turns the PWM inputs into registered high-side and low-side gate enables. The decoding follows one of three input modes: six independent inputs, three level-plus-enable pairs, or a single duty input with externally decoded phase selects. It also applies a brake override, and it shuts the bridge down when an overcurrent detector fires.

The brake has two sources, a pin and a register bit, and either one is enough. The active-low pin is honoured only in single-input mode. The active-high register bit works in every mode. The overcurrent policy comes from a 2-bit mode field. Latched mode holds the fault until software clears it. Retry mode lets a PWM input change clear the fault, or lets a timer clear it. Report-only mode raises the flag but leaves the gates alone. No-action mode ignores the detector. A fault that shuts the bridge down always beats the brake.

Top module: `bridge_guard`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all gate enables and the fault flag are 0.
- R2: Six-input mode (mode 2'b00): the gate outputs are updated one clock after the inputs are sampled. For phase k, pwm_in[k] requests the high side and pwm_in[k+3] requests the low side. A phase whose two requests are both 1 has both enables off. No phase ever has both enables on.
- R3: Three-input mode (mode 2'b01): pwm_in[k+3] enables phase k. While it is enabled, pwm_in[k]=1 drives the high side and pwm_in[k]=0 drives the low side. A disabled phase has both enables off.
- R4: Single-input mode (mode 2'b10): pwm_in[0] is the duty and pwm_in[k+3] selects phase k. A selected phase drives its high side while the duty is 1 and its low side while the duty is 0. An unselected phase is off.
- R5: Brake is asserted when brake_n is low in single-input mode, or when brake_bit is 1 in any mode. While brake is asserted, all high sides are off and all low sides are on. In the other two modes brake_n has no effect.
- R6: In latched (ocp_mode 2'b00) or retry (2'b01) mode, an active oc_det bit sets fault_flag and turns off all six gates on the same edge. This shutdown also overrides brake.
- R7: In retry mode with cbc=1, a change on any pwm_in bit while oc_det is inactive clears the fault on the next edge.
- R8: In retry mode with cbc=0, PWM changes do not clear the fault. The fault clears RETRY_CYCLES edges after the last edge that saw oc_det active, and the gates resume on that same edge.
- R9: In latched mode, PWM changes never clear the fault, whatever cbc is. A fault_clr pulse clears the fault only while oc_det is inactive.
- R10: In report-only mode (2'b10), oc_det sets fault_flag but the gate outputs follow the normal decoding. The flag stays set until a fault_clr pulse.
- R11: In no-action mode (2'b11), oc_det neither sets fault_flag nor changes the gate outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_mode | input | 2 | Input decoding: 00 six-input, 01 three-input, 10 single-input |
| pwm_in | input | 6 | PWM inputs, meaning set by pwm_mode |
| brake_n | input | 1 | Active-low brake pin, honoured in single-input mode |
| brake_bit | input | 1 | Active-high brake register bit |
| cbc | input | 1 | Allow PWM input changes to clear a retry-mode fault |
| ocp_mode | input | 2 | 00 latched, 01 retry, 10 report only, 11 no action |
| fault_clr | input | 1 | One-cycle fault clear pulse |
| oc_det | input | 3 | Per-phase overcurrent detect, active high |
| gate_hi | output | 3 | High-side gate enables, one per phase |
| gate_lo | output | 3 | Low-side gate enables, one per phase |
| fault_flag | output | 1 | Overcurrent fault pending |

## Verification
Some rules hold on every cycle, and the assertions check those: no phase has both enables on, shutdown blanks all six gates and overrides brake, brake forces the low-side pattern, and a detect sets the fault. They also check that latched and cbc-off retry faults survive PWM changes, and that a cbc-on PWM change clears a retry fault. Other behaviour needs a chosen stimulus, so only the bench scenarios can show it. That covers the per-mode decode tables, the brake pin being ignored outside single-input mode, the exact retry timeout edge, fault_clr being refused while the detector is still active, and report-only mode leaving the gates running.

// File: rtl/bg_pkg.sv
package bg_pkg;
   typedef enum logic [1:0] {
      PWM_SIX   = 2'b00,
      PWM_THREE = 2'b01,
      PWM_ONE   = 2'b10,
      PWM_RSVD  = 2'b11
   } pwm_mode_e;

   typedef enum logic [1:0] {
      OCP_LATCH  = 2'b00,
      OCP_RETRY  = 2'b01,
      OCP_REPORT = 2'b10,
      OCP_NONE   = 2'b11
   } ocp_mode_e;
endpackage

// File: rtl/bg_phase_map.sv
module bg_phase_map
   import bg_pkg::*;
#(
   parameter int PHASES = 3
) (
   input  logic [1:0]          mode,
   input  logic [2*PHASES-1:0] pwm,
   input  logic                brake_n,
   input  logic                brake_bit,
   input  logic                shutdown,
   output logic                brake_req,
   output logic [PHASES-1:0]   hi_d,
   output logic [PHASES-1:0]   lo_d
);
   assign brake_req = brake_bit | ((mode == PWM_ONE) & ~brake_n);

   for (genvar k = 0; k < PHASES; k++) begin : g_phase
      logic req_h, req_l;
      always_comb begin
         unique case (mode)
            PWM_SIX: begin
               req_h = pwm[k] & ~pwm[k+PHASES];
               req_l = pwm[k+PHASES] & ~pwm[k];
            end
            PWM_THREE: begin
               req_h = pwm[k+PHASES] & pwm[k];
               req_l = pwm[k+PHASES] & ~pwm[k];
            end
            PWM_ONE: begin
               req_h = pwm[k+PHASES] & pwm[0];
               req_l = pwm[k+PHASES] & ~pwm[0];
            end
            default: begin
               req_h = 1'b0;
               req_l = 1'b0;
            end
         endcase
      end

      always_comb begin
         if (shutdown) begin
            hi_d[k] = 1'b0;
            lo_d[k] = 1'b0;
         end else if (brake_req) begin
            hi_d[k] = 1'b0;
            lo_d[k] = 1'b1;
         end else begin
            hi_d[k] = req_h;
            lo_d[k] = req_l;
         end
      end
   end
endmodule

// File: rtl/bg_fault.sv
module bg_fault
   import bg_pkg::*;
#(
   parameter int PHASES       = 3,
   parameter int RETRY_CYCLES = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          ocp_mode,
   input  logic                cbc,
   input  logic                fault_clr,
   input  logic [PHASES-1:0]   oc_det,
   input  logic [2*PHASES-1:0] pwm,
   output logic                fault_q,
   output logic                shutdown_d
);
   localparam int CW = $clog2(RETRY_CYCLES + 1);
   localparam logic [CW-1:0] RELOAD = CW'(RETRY_CYCLES - 1);

   if (RETRY_CYCLES < 2) begin : g_bad_retry
      $error("bg_fault: RETRY_CYCLES must be at least 2");
   end

   logic [2*PHASES-1:0] pwm_prev;
   logic [CW-1:0]       cnt_q, cnt_d;
   logic                fault_d, oc_any, pwm_edge;

   assign oc_any   = |oc_det;
   assign pwm_edge = pwm != pwm_prev;

   always_comb begin
      fault_d = fault_q;
      cnt_d   = cnt_q;
      if (ocp_mode == OCP_NONE) begin
         fault_d = 1'b0;
      end else if (oc_any) begin
         fault_d = 1'b1;
         cnt_d   = RELOAD;
      end else if (fault_q) begin
         if (ocp_mode == OCP_RETRY) begin
            if ((cbc && pwm_edge) || cnt_q == '0) fault_d = 1'b0;
            else                                 cnt_d   = cnt_q - 1'b1;
         end else if (fault_clr) begin
            fault_d = 1'b0;
         end
      end
   end

   assign shutdown_d = fault_d & ((ocp_mode == OCP_LATCH) | (ocp_mode == OCP_RETRY));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q  <= 1'b0;
         cnt_q    <= '0;
         pwm_prev <= '0;
      end else begin
         fault_q  <= fault_d;
         cnt_q    <= cnt_d;
         pwm_prev <= pwm;
      end
   end

   a_r6_detect_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_any && ocp_mode != OCP_NONE) |=> fault_q);
   a_r7_cbc_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q && ocp_mode == OCP_RETRY && cbc && pwm_edge && !oc_any) |=> !fault_q);
   a_r8_edge_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q && ocp_mode == OCP_RETRY && !cbc && cnt_q != '0) |=> fault_q);
   a_r9_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q && ocp_mode == OCP_LATCH && !fault_clr) |=> fault_q);
   a_r11_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (ocp_mode == OCP_NONE) |=> !fault_q);
endmodule

// File: rtl/bridge_guard.sv
module bridge_guard
   import bg_pkg::*;
#(
   parameter int PHASES       = 3,
   parameter int RETRY_CYCLES = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          pwm_mode,
   input  logic [2*PHASES-1:0] pwm_in,
   input  logic                brake_n,
   input  logic                brake_bit,
   input  logic                cbc,
   input  logic [1:0]          ocp_mode,
   input  logic                fault_clr,
   input  logic [PHASES-1:0]   oc_det,
   output logic [PHASES-1:0]   gate_hi,
   output logic [PHASES-1:0]   gate_lo,
   output logic                fault_flag
);
   if (PHASES < 1) begin : g_bad_phases
      $error("bridge_guard: PHASES must be at least 1");
   end

   logic              shutdown_d, brake_req;
   logic [PHASES-1:0] hi_d, lo_d;

   bg_fault #(.PHASES(PHASES), .RETRY_CYCLES(RETRY_CYCLES)) u_fault (
      .clk        (clk),
      .rst_n      (rst_n),
      .ocp_mode   (ocp_mode),
      .cbc        (cbc),
      .fault_clr  (fault_clr),
      .oc_det     (oc_det),
      .pwm        (pwm_in),
      .fault_q    (fault_flag),
      .shutdown_d (shutdown_d)
   );

   bg_phase_map #(.PHASES(PHASES)) u_map (
      .mode      (pwm_mode),
      .pwm       (pwm_in),
      .brake_n   (brake_n),
      .brake_bit (brake_bit),
      .shutdown  (shutdown_d),
      .brake_req (brake_req),
      .hi_d      (hi_d),
      .lo_d      (lo_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_hi <= '0;
         gate_lo <= '0;
      end else begin
         gate_hi <= hi_d;
         gate_lo <= lo_d;
      end
   end

   a_r2_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_hi & gate_lo) == '0);
   a_r6_shutdown_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_d |=> (gate_hi == '0 && gate_lo == '0));
   a_r5_brake_pattern: assert property (@(posedge clk) disable iff (!rst_n)
      (brake_req && !shutdown_d) |=> (gate_hi == '0 && gate_lo == '1));
endmodule

// File: tb/tb_bridge_guard.sv
`timescale 1ns/1ps
module tb_bridge_guard;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pwm_mode = 2'b00;
   logic [5:0] pwm_in = '0;
   logic       brake_n = 1'b1, brake_bit = 1'b0, cbc = 1'b1, fault_clr = 1'b0;
   logic [1:0] ocp_mode = 2'b00;
   logic [2:0] oc_det = '0;
   logic [2:0] gate_hi, gate_lo;
   logic       fault_flag;
   int         n_chk = 0, n_bad = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   bridge_guard dut (
      .clk(clk), .rst_n(rst_n), .pwm_mode(pwm_mode), .pwm_in(pwm_in),
      .brake_n(brake_n), .brake_bit(brake_bit), .cbc(cbc), .ocp_mode(ocp_mode),
      .fault_clr(fault_clr), .oc_det(oc_det),
      .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_flag(fault_flag)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // observed word: {fault_flag, gate_hi[2:0], gate_lo[2:0]}
   task automatic chk(string req, logic [6:0] exp);
      logic [6:0] act;
      act = {fault_flag, gate_hi, gate_lo};
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic clear_all();
      ocp_mode = 2'b11; oc_det = '0; brake_bit = 1'b0; brake_n = 1'b1;
      fault_clr = 1'b0; pwm_in = '0; pwm_mode = 2'b00;
      step();
      ocp_mode = 2'b00;
      step();
   endtask

   task automatic t_reset();
      pwm_in = 6'b000_111;
      repeat (3) @(negedge clk);
      chk("R1 in reset", 7'b0_000_000);
      rst_n = 1'b1;
      pwm_in = '0;
      step();
      chk("R1 after reset", 7'b0_000_000);
   endtask

   task automatic t_six();
      pwm_mode = 2'b00;
      pwm_in = 6'b000_101; step();
      chk("R2 high sides", 7'b0_101_000);
      pwm_in = 6'b011_001; step();
      chk("R2 conflict off", 7'b0_000_010);
   endtask

   task automatic t_three();
      pwm_mode = 2'b01;
      pwm_in = 6'b101_100; step();
      chk("R3 level/enable", 7'b0_100_001);
   endtask

   task automatic t_one();
      pwm_mode = 2'b10; brake_n = 1'b1;
      pwm_in = 6'b011_001; step();
      chk("R4 duty high", 7'b0_011_000);
      pwm_in = 6'b011_000; step();
      chk("R4 duty low", 7'b0_000_011);
   endtask

   task automatic t_brake();
      pwm_mode = 2'b10; pwm_in = 6'b011_001; brake_n = 1'b0; step();
      chk("R5 pin brake single mode", 7'b0_000_111);
      pwm_mode = 2'b00; pwm_in = 6'b000_111; step();
      chk("R5 pin ignored six mode", 7'b0_111_000);
      pwm_mode = 2'b01; pwm_in = 6'b111_111; step();
      chk("R5 pin ignored three mode", 7'b0_111_000);
      brake_n = 1'b1; brake_bit = 1'b1; step();
      chk("R5 register brake", 7'b0_000_111);
      brake_bit = 1'b0;
   endtask

   task automatic t_latch();
      clear_all();
      ocp_mode = 2'b00; cbc = 1'b1; brake_bit = 1'b1; oc_det = 3'b001; step();
      chk("R6 shutdown over brake", 7'b1_000_000);
      fault_clr = 1'b1; step();
      fault_clr = 1'b0;
      chk("R9 clear refused while detect", 7'b1_000_000);
      oc_det = '0; step();
      pwm_in = 6'b000_010; step();
      chk("R9 pwm change ignored", 7'b1_000_000);
      fault_clr = 1'b1; step();
      fault_clr = 1'b0;
      chk("R9 clear pulse", 7'b0_000_111);
      brake_bit = 1'b0;
   endtask

   task automatic t_retry_cbc();
      clear_all();
      ocp_mode = 2'b01; cbc = 1'b1; pwm_in = 6'b000_001; oc_det = 3'b100; step();
      chk("R6 retry shutdown", 7'b1_000_000);
      oc_det = '0; step();
      chk("R7 held without edge", 7'b1_000_000);
      pwm_in = 6'b000_010; step();
      chk("R7 edge clears", 7'b0_010_000);
   endtask

   task automatic t_retry_timer();
      clear_all();
      ocp_mode = 2'b01; cbc = 1'b0; pwm_in = 6'b000_001; oc_det = 3'b010; step();
      oc_det = '0; pwm_in = 6'b000_100; step();
      chk("R8 edge does not clear", 7'b1_000_000);
      for (int i = 0; i < 62; i++) step();
      chk("R8 held before timeout", 7'b1_000_000);
      step();
      chk("R8 timeout clears", 7'b0_100_000);
      cbc = 1'b1;
   endtask

   task automatic t_report();
      clear_all();
      ocp_mode = 2'b10; pwm_in = 6'b000_001; oc_det = 3'b001; step();
      chk("R10 flag gates run", 7'b1_001_000);
      oc_det = '0; pwm_in = 6'b000_010; step();
      chk("R10 flag held", 7'b1_010_000);
      fault_clr = 1'b1; step();
      fault_clr = 1'b0;
      chk("R10 cleared", 7'b0_010_000);
   endtask

   task automatic t_none();
      clear_all();
      ocp_mode = 2'b11; pwm_in = 6'b000_001; oc_det = 3'b111; step();
      chk("R11 no flag no shutdown", 7'b0_001_000);
      oc_det = '0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      t_reset();
      t_six();
      t_three();
      t_one();
      t_brake();
      t_latch();
      t_retry_cbc();
      t_retry_timer();
      t_report();
      t_none();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule